// File: doc/BRIEF.md
# UART Receive Queue with Trigger Count and Idle Timeout

This block holds the bytes a UART receiver has collected until software reads them. Incoming bytes from the deserializer, and line-break events, are written into a circular byte store of parameterized depth. Each read request returns the oldest byte held. The current fill level is driven out continuously so a neighbouring status unit can derive full, empty and trigger flags from it.

Two single-cycle event pulses go to the interrupt unit. One reports that a byte was lost because the store was full. The other reports that the line has gone quiet: a set number of character periods have passed since the last byte was accepted. The character period arrives as a strobe from the baud logic. A small control interface carries a receiver enable, a receiver disable and a self-clearing flush request.

Top module: `uart_rxq`

## Requirements
- R1: Writes and reads take effect only while the stored enable bit (control bit 2) is 1 and the stored disable bit (control bit 3) is 0. A control write updates both bits and takes effect from the next cycle. After reset the enable bit is 0 and the disable bit is 1. While the receiver is off, incoming bytes are dropped and read requests leave `rd_data_o` and `count_o` unchanged.
- R2: Each accepted byte raises `count_o` by one in the cycle after the write. `count_o` is one bit wider than the store address.
- R3: A read request returns the oldest byte held on `rd_data_o` in the cycle after the request and lowers `count_o` by one. Bytes come out in the order they arrived, across pointer wrap.
- R4: A byte that arrives while `count_o` equals DEPTH is discarded, and `ovr_pulse_o` is 1 for exactly the next cycle. No overrun pulse is produced in any other case.
- R5: Every accepted byte restarts an idle timer. `tmo_pulse_o` is 1 for one cycle, in the cycle after the TMO_CHARS-th `char_tick_i` strobe that follows the last accepted byte. A byte accepted in the same cycle as that strobe restarts the timer instead of firing it.
- R6: A read request while the store is empty drives 0x00 on `rd_data_o` and leaves `count_o` at zero.
- R7: A line break (`rx_break_i`) stores a 0x00 byte. If a break and a data byte arrive in the same cycle, only the single 0x00 byte is stored.
- R8: An accepted write and a read in the same cycle leave `count_o` unchanged.
- R9: A control write with bit 0 set empties the store and returns the write position to the start. The bit is not held. Bits 2 and 3 of the same write still update the enable state.
- R10: After reset `count_o`, `rd_data_o`, `ovr_pulse_o` and `tmo_pulse_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_data_i | input | 4 | Control value: bit0 flush, bit2 enable, bit3 disable (bit1 unused) |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Line break detected |
| rd_req_i | input | 1 | Read request from the data register |
| char_tick_i | input | 1 | One-cycle strobe per character period |
| rd_data_o | output | 8 | Byte returned by the last read |
| count_o | output | $clog2(DEPTH)+1 | Number of bytes held |
| ovr_pulse_o | output | 1 | Overrun event pulse |
| tmo_pulse_o | output | 1 | Idle timeout event pulse |

## Verification
The assertions assume that every input strobe lasts one clock cycle and is synchronous to `clk`, and that a flush request is never combined with byte traffic in the same cycle. The stimulus drives all inputs at the falling edge and holds each for exactly one cycle. Random traffic runs with the receiver enabled and control writes appear only in directed sequences. Fill-heavy and drain-heavy phases push the count into both extremes, so overrun and empty reads occur under random traffic as well as in the directed cases.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int BYTE_W    = 8;
  localparam int CTRL_W    = 4;
  localparam int CTRL_CLR  = 0;
  localparam int CTRL_EN   = 2;
  localparam int CTRL_DIS  = 3;
  typedef logic [BYTE_W-1:0] rx_byte_t;
endpackage

// File: rtl/uart_rxq_gate.sv
module uart_rxq_gate
  import uart_rxq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  output logic              rx_on_o,
  output logic              clr_o
);
  logic en_q, en_d, dis_q, dis_d;

  always_comb begin
    en_d  = en_q;
    dis_d = dis_q;
    if (ctrl_wr_i) begin
      en_d  = ctrl_data_i[CTRL_EN];
      dis_d = ctrl_data_i[CTRL_DIS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dis_q <= 1'b1;
    end else begin
      en_q  <= en_d;
      dis_q <= dis_d;
    end
  end

  assign rx_on_o = en_q & ~dis_q;
  assign clr_o   = ctrl_wr_i & ctrl_data_i[CTRL_CLR];

  // R1: a control write is reflected in the gate on the following cycle
  a_r1_ctrl_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_i |=> (rx_on_o == ($past(ctrl_data_i[CTRL_EN]) & ~$past(ctrl_data_i[CTRL_DIS]))));
endmodule

// File: rtl/uart_rxq_store.sv
module uart_rxq_store
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic                     push_i,
  input  rx_byte_t                 push_data_i,
  input  logic                     pop_i,
  output logic [$clog2(DEPTH):0]   count_o,
  output rx_byte_t                 rd_data_o,
  output logic                     ovr_o,
  output logic                     accept_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  rx_byte_t        mem_q [DEPTH];
  logic [PW-1:0]   wp_q, wp_d, rp;
  logic [CW-1:0]   cnt_q, cnt_d;
  rx_byte_t        rd_q, rd_d;
  logic            ovr_q, ovr_d;
  logic            full, empty, wr_ok, rd_ok;
  logic [CW:0]     rp_wide;

  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);
  assign wr_ok = push_i & ~full & ~clr_i;
  assign rd_ok = pop_i & ~empty & ~clr_i;

  // oldest entry sits count positions behind the write position
  always_comb begin
    rp_wide = {2'b00, wp_q} - {1'b0, cnt_q};
    if ({2'b00, wp_q} < {1'b0, cnt_q}) rp_wide = rp_wide + (CW+1)'(DEPTH);
    rp = rp_wide[PW-1:0];
  end

  always_comb begin
    wp_d  = wp_q;
    cnt_d = cnt_q;
    rd_d  = rd_q;
    ovr_d = 1'b0;
    if (clr_i) begin
      wp_d  = '0;
      cnt_d = '0;
    end else begin
      if (wr_ok) wp_d = (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
      if (pop_i) rd_d = empty ? '0 : mem_q[rp];
      ovr_d = push_i & full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
      rd_q  <= '0;
      ovr_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
      rd_q  <= rd_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wp_q] <= push_data_i;
  end

  assign count_o   = cnt_q;
  assign rd_data_o = rd_q;
  assign ovr_o     = ovr_q;
  assign accept_o  = wr_ok;

  a_r2_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  a_r4_ovr_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !full) |=> !ovr_q);
  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty && !clr_i) |=> (rd_q == '0 && cnt_q == (CW'(1) & CW'($past(wr_ok)))));
  a_r8_rw_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !full && !empty && !clr_i) |=> $stable(cnt_q));
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && wp_q == '0));
endmodule

// File: rtl/uart_rxq_idle_timer.sv
module uart_rxq_idle_timer #(
  parameter int TMO_CHARS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic tick_i,
  output logic tmo_o
);
  localparam int TW = $clog2(TMO_CHARS + 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(TMO_CHARS - 1);

  logic          armed_q, armed_d;
  logic [TW-1:0] cnt_q, cnt_d;
  logic          tmo_q, tmo_d;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    tmo_d   = 1'b0;
    if (restart_i) begin
      armed_d = 1'b1;
      cnt_d   = '0;
    end else if (armed_q && tick_i) begin
      if (cnt_q == LAST_TICK) begin
        tmo_d   = 1'b1;
        armed_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      tmo_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
    end
  end

  assign tmo_o = tmo_q;

  a_r5_tmo_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |-> $past(tick_i && armed_q && !restart_i));
  a_r5_restart_blocks_tmo: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !tmo_q);
endmodule

// File: rtl/uart_rxq.sv
module uart_rxq
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int TMO_CHARS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ctrl_wr_i,
  input  logic [3:0]             ctrl_data_i,
  input  logic                   rx_valid_i,
  input  logic [7:0]             rx_data_i,
  input  logic                   rx_break_i,
  input  logic                   rd_req_i,
  input  logic                   char_tick_i,
  output logic [7:0]             rd_data_o,
  output logic [$clog2(DEPTH):0] count_o,
  output logic                   ovr_pulse_o,
  output logic                   tmo_pulse_o
);
  logic     rx_on, clr, push, pop, accept;
  rx_byte_t push_data;

  uart_rxq_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_wr_i   (ctrl_wr_i),
    .ctrl_data_i (ctrl_data_i),
    .rx_on_o     (rx_on),
    .clr_o       (clr)
  );

  assign push      = rx_on & (rx_valid_i | rx_break_i);
  assign push_data = rx_break_i ? '0 : rx_data_i;
  assign pop       = rx_on & rd_req_i;

  uart_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .count_o     (count_o),
    .rd_data_o   (rd_data_o),
    .ovr_o       (ovr_pulse_o),
    .accept_o    (accept)
  );

  uart_rxq_idle_timer #(.TMO_CHARS(TMO_CHARS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (accept),
    .tick_i    (char_tick_i),
    .tmo_o     (tmo_pulse_o)
  );

  a_r1_off_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_on && !clr) |=> ($stable(count_o) && $stable(rd_data_o) && !ovr_pulse_o));
  a_r7_break_stores_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_on && rx_break_i && !clr && count_o == '0 && !rd_req_i) |=> (count_o == 1));
endmodule

// File: tb/uart_rxq_tb_top.sv
module uart_rxq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int TMO        = 4;
  localparam int CW         = $clog2(DEPTH) + 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctrl_wr;
  logic [3:0]    ctrl_data;
  logic          rx_valid, rx_break, rd_req, tick;
  logic [7:0]    rx_data, rd_data;
  logic [CW-1:0] count;
  logic          ovr, tmo;

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;

  byte unsigned q[$];
  bit          m_en = 1'b0, m_dis = 1'b1;
  byte unsigned exp_rd = 8'h00;
  bit          exp_ovr = 1'b0, exp_tmo = 1'b0, t_armed = 1'b0;
  int          t_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rxq #(.DEPTH(DEPTH), .TMO_CHARS(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .ctrl_data_i(ctrl_data),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_break_i(rx_break),
    .rd_req_i(rd_req), .char_tick_i(tick), .rd_data_o(rd_data),
    .count_o(count), .ovr_pulse_o(ovr), .tmo_pulse_o(tmo)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_errors++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One cycle: drive inputs, advance the model, check outputs after the edge.
  task automatic step(bit wr, byte unsigned d, bit brk, bit rd, bit tk,
                      bit cw, bit [3:0] cd, string tag);
    bit on, clr, full, emp, acc;
    rx_valid = wr; rx_data = d; rx_break = brk; rd_req = rd;
    tick = tk; ctrl_wr = cw; ctrl_data = cd;
    on  = m_en && !m_dis;
    clr = cw && cd[0];
    acc = 1'b0;
    exp_ovr = 1'b0;
    if (clr) q.delete();
    else if (on) begin
      full = (q.size() == DEPTH);
      emp  = (q.size() == 0);
      if (rd) exp_rd = emp ? 8'h00 : q[0];
      if (wr || brk) begin
        if (full) exp_ovr = 1'b1;
        else acc = 1'b1;
      end
      if (rd && !emp) void'(q.pop_front());
      if (acc) q.push_back(brk ? 8'h00 : d);
    end
    exp_tmo = 1'b0;
    if (acc) begin t_armed = 1'b1; t_cnt = 0; end
    else if (t_armed && tk) begin
      if (t_cnt == TMO-1) begin exp_tmo = 1'b1; t_armed = 1'b0; t_cnt = 0; end
      else t_cnt++;
    end
    if (cw) begin m_en = cd[2]; m_dis = cd[3]; end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "count", int'(count), q.size());
    chk(tag, "rd_data", int'(rd_data), int'(exp_rd));
    chk(tag, "ovr_pulse", int'(ovr), int'(exp_ovr));
    chk(tag, "tmo_pulse", int'(tmo), int'(exp_tmo));
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    rst_n = 1'b0;
    ctrl_wr = 0; ctrl_data = 0; rx_valid = 0; rx_data = 0;
    rx_break = 0; rd_req = 0; tick = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "count", int'(count), 0);
    chk("R10", "rd_data", int'(rd_data), 0);
    chk("R10", "ovr_pulse", int'(ovr), 0);
    chk("R10", "tmo_pulse", int'(tmo), 0);

    // R1: off after reset, writes and reads ignored
    step(1, 8'h5A, 0, 0, 0, 0, 0, "R1");
    step(1, 8'h11, 0, 1, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 1, 4'b0100, "R1");        // enable
    step(1, 8'h3C, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 1, 4'b1100, "R1");        // enable and disable both set: off
    step(1, 8'h77, 0, 1, 0, 0, 0, "R1");
    step(0, 0, 0, 1, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 1, 4'b0100, "R1");
    step(0, 0, 0, 1, 0, 0, 0, "R1");              // returns 0x3C

    // R2/R3: push a sequence, read it back in order
    for (int i = 0; i < 5; i++) step(1, 8'(8'hA0 + i), 0, 0, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, 0, "R3");

    // R6: empty read returns zero
    step(1, 8'hEE, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 1, 0, 0, 0, "R6");

    // R4: fill to DEPTH, then overflow
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 3 + 1), 0, 0, 0, 0, 0, "R4");
    step(1, 8'hF0, 0, 0, 0, 0, 0, "R4");
    step(1, 8'hF1, 0, 1, 0, 0, 0, "R4");          // full: dropped, read proceeds
    step(1, 8'hF2, 0, 0, 0, 0, 0, "R4");          // one slot free: accepted
    idle("R4");
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 0, 1, 0, 0, 0, "R3");

    // R7: break stores zero, also when data arrives with it
    step(1, 8'h99, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 0, 0, 0, "R7");
    step(1, 8'h55, 1, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, 0, 0, "R7");

    // R8: simultaneous read and write
    step(1, 8'h21, 0, 0, 0, 0, 0, "R8");
    step(1, 8'h22, 0, 1, 0, 0, 0, "R8");
    step(1, 8'h23, 0, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 0, 0, "R8");

    // R9: flush keeps enable, write position restarts
    for (int i = 0; i < 3; i++) step(1, 8'(8'h40 + i), 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 1, 4'b0101, "R9");
    step(1, 8'h6B, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 0, 0, 0, "R9");

    // R5: timeout four ticks after last accepted byte, restart on new byte
    step(1, 8'h01, 0, 0, 0, 0, 0, "R5");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0, "R5");
    step(1, 8'h02, 0, 0, 1, 0, 0, "R5");          // restart wins over 4th tick
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 0, 1, 0, 0, "R5");
      idle("R5");
    end
    step(0, 0, 0, 0, 1, 0, 0, "R5");
    idle("R5");                                   // pulse seen on previous step
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 0, 0, "R5");
    step(0, 0, 0, 1, 0, 0, 0, "R5");
    step(0, 0, 0, 1, 0, 0, 0, "R5");

    // random traffic: fill-heavy, drain-heavy, balanced
    for (int ph = 0; ph < 6; ph++) begin
      for (int i = 0; i < 700; i++) begin
        int wp, rp;
        wp = (ph % 3 == 0) ? 85 : (ph % 3 == 1) ? 15 : 50;
        rp = (ph % 3 == 0) ? 15 : (ph % 3 == 1) ? 85 : 45;
        step(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < 4,
             ($urandom % 100) < rp, ($urandom % 100) < 20, 0, 0, "R3");
      end
    end
    finish_run();
  end
endmodule